// File: doc/BRIEF.md
# Three-Address Register Machine Core

This block is a compact processor core built around a data register file with no accumulator. Every arithmetic instruction names two source registers and one destination register, and any of the three may be the same register. The instruction set covers loading an immediate constant, addition, subtraction, two copy forms that go through a pointer register (indirect source and indirect destination), a branch taken only when a register holds a strictly positive value, and word-level input and output over valid/ready streams. A halt instruction stops the core until the next reset.

Instructions come from an external program ROM that is read combinationally: the core presents a fetch address and expects the instruction word back in the same cycle. Each instruction completes in one cycle. The only exceptions are a read with no input word available and a print whose output is not accepted; each of these holds the core on that instruction. Registers hold signed two's-complement words, and arithmetic wraps modulo 2^DATA_W.

Top module: `tam_core`

## Requirements
- R1: A reset (rst_n low at a clock edge) sets the fetch address to 0, clears the halt flag and clears every register to 0. A reset also takes effect in the middle of a program.
- R2: Opcode 1 (load-constant) writes the 16-bit immediate field into register d, so an immediate of 0 clears that register.
- R3: Opcode 2 (add) writes [s1]+[s2], modulo 2^DATA_W, into register d.
- R4: Opcode 3 (subtract) writes [s1]−[s2], modulo 2^DATA_W, into register d. Subtracting a register from itself into itself clears it.
- R5: Opcode 4 (indirect-source copy) writes into register d the contents of the register whose index is the low log2(NREG) bits of [s1]. A register may point to itself.
- R6: Opcode 5 (indirect-destination copy) writes [s1] into the register whose index is the low log2(NREG) bits of [d].
- R7: Opcode 6 (branch) loads the low PC_W bits of the immediate field into the fetch address when [s1] is nonzero with its sign bit clear. Otherwise the address advances by one.
- R8: Opcode 7 (read) raises in_ready and holds the fetch address until in_valid is high. In the cycle where both are high, it writes in_data into register d and advances.
- R9: Opcode 8 (print) raises out_valid with out_data = [s1] and holds the fetch address and out_data until out_ready is high. In the cycle where both are high, the word transfers and the core advances.
- R10: All source operands are read before the destination is written, so an instruction whose sources alias its destination uses the old values (adding a register to itself into itself doubles it).
- R11: Opcode 0 (halt) sets the halt flag at the next edge. The flag then stays set until reset, the fetch address stays frozen, and in_ready and out_valid stay low.
- R12: The instruction word is {op[31:28], d[27:24], s1[23:20], s2[19:16], imm[15:0]} at the default parameters. Opcodes 9 to 15 change no register and advance the fetch address by one. Otherwise the fetch address advances by one, modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | PC_W | Fetch address to the program ROM |
| rom_data | input | 4+3*log2(NREG)+DATA_W | Instruction word at rom_addr, same cycle |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Core is executing a read |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Core is executing a print |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Output word, [s1] of the current instruction |
| halted | output | 1 | Halt flag |

## Verification
The properties assume the program ROM returns a fixed word for each address throughout a run and answers within the same cycle. The stall and halt checks depend on this, because they expect an unchanged fetch address to yield an unchanged instruction. The stream inputs are left unconstrained: in_valid and out_ready may toggle in any cycle. The bench writes program contents only while reset is held. It drives the two handshake inputs at varied acceptance rates, including always-ready, so that both stalls and back-to-back transfers occur.

// File: rtl/tam_pkg.sv
`timescale 1ns/1ps
// Shared opcode values and write-source selector for the three-address core.
// Assumes a 4-bit opcode field at the top of every instruction word.
package tam_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_HALT  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_LDC   = 4'd1;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'd3;
    localparam logic [OPC_W-1:0] OPC_CPYI  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_CPYO  = 4'd5;
    localparam logic [OPC_W-1:0] OPC_JPOS  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_READ  = 4'd7;
    localparam logic [OPC_W-1:0] OPC_PRINT = 4'd8;

    // Which value an instruction deposits into the register file.
    typedef enum logic [2:0] {
        WS_NONE,
        WS_IMM,
        WS_SUM,
        WS_DIFF,
        WS_IND,
        WS_SRC,
        WS_INPUT
    } wsel_e;
endpackage

// File: rtl/tam_decode.sv
`timescale 1ns/1ps
// Splits an instruction word into its fields and derives control flags.
// Assumes the layout {op, d, s1, s2, imm}, most significant field first.
// Undefined opcodes decode to a plain no-operation.
module tam_decode
    import tam_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RA_W   = 4
) (
    input  logic [OPC_W+3*RA_W+DATA_W-1:0] instr,
    output logic [RA_W-1:0]                d_idx,
    output logic [RA_W-1:0]                s1_idx,
    output logic [RA_W-1:0]                s2_idx,
    output logic [DATA_W-1:0]              imm,
    output wsel_e                          wsel,
    output logic                           is_halt,
    output logic                           is_read,
    output logic                           is_print,
    output logic                           is_jpos
);
    localparam int INSTR_W = OPC_W + 3*RA_W + DATA_W;
    localparam int D_HI    = INSTR_W - OPC_W - 1;
    localparam int S1_HI   = D_HI - RA_W;
    localparam int S2_HI   = S1_HI - RA_W;

    logic [OPC_W-1:0] opc;

    // Field extraction at fixed positions.
    always_comb begin
        opc    = instr[INSTR_W-1 -: OPC_W];
        d_idx  = instr[D_HI -: RA_W];
        s1_idx = instr[S1_HI -: RA_W];
        s2_idx = instr[S2_HI -: RA_W];
        imm    = instr[DATA_W-1:0];
    end

    // Opcode to control flags.
    always_comb begin
        wsel     = WS_NONE;
        is_halt  = 1'b0;
        is_read  = 1'b0;
        is_print = 1'b0;
        is_jpos  = 1'b0;
        case (opc)
            OPC_HALT:  is_halt = 1'b1;
            OPC_LDC:   wsel = WS_IMM;
            OPC_ADD:   wsel = WS_SUM;
            OPC_SUB:   wsel = WS_DIFF;
            OPC_CPYI:  wsel = WS_IND;
            OPC_CPYO:  wsel = WS_SRC;
            OPC_JPOS:  is_jpos = 1'b1;
            OPC_READ: begin
                is_read = 1'b1;
                wsel    = WS_INPUT;
            end
            OPC_PRINT: is_print = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/tam_regfile.sv
`timescale 1ns/1ps
// Data register file: NRD direct asynchronous read ports, one extra read
// port for pointer-chased reads, one synchronous write port.
// Assumes NREG == 2**RA_W so every index names a real register.
// All reads see the state before the current edge's write.
module tam_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int RA_W   = 4,
    parameter int NRD    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [RA_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [NRD-1:0][RA_W-1:0]    rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]  rd_data,
    input  logic [RA_W-1:0]             ptr_idx,
    output logic [DATA_W-1:0]           ptr_data
);
    logic [NREG-1:0][DATA_W-1:0] regs;

    // Storage: clear on reset, single write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Direct read ports.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = regs[rd_idx[p]];
    end

    // Pointer-chased read port.
    assign ptr_data = regs[ptr_idx];
endmodule

// File: rtl/tam_exec.sv
`timescale 1ns/1ps
// Datapath for one instruction: adder/subtractor, write-back selection,
// pointer index extraction and the positive-value branch test.
// Assumes PC_W <= DATA_W (branch targets come from the immediate field).
module tam_exec
    import tam_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RA_W   = 4,
    parameter int PC_W   = 8
) (
    input  wsel_e             wsel,
    input  logic              is_jpos,
    input  logic [RA_W-1:0]   d_idx,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] s1_val,
    input  logic [DATA_W-1:0] s2_val,
    input  logic [DATA_W-1:0] d_val,
    input  logic [DATA_W-1:0] ind_val,
    input  logic [DATA_W-1:0] in_data,
    output logic [RA_W-1:0]   ind_idx,
    output logic              wr_req,
    output logic [RA_W-1:0]   wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              br_take,
    output logic [PC_W-1:0]   br_target
);
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] diff;
    logic [RA_W-1:0]   d_ptr;

    // Arithmetic on the old operand values.
    always_comb begin
        sum  = s1_val + s2_val;
        diff = s1_val - s2_val;
    end

    // Pointer indexes are the low bits of the pointer register.
    always_comb begin
        ind_idx = RA_W'(s1_val);
        d_ptr   = RA_W'(d_val);
    end

    // Write-back value and destination selection.
    always_comb begin
        wr_req = (wsel != WS_NONE);
        wr_idx = (wsel == WS_SRC) ? d_ptr : d_idx;
        case (wsel)
            WS_IMM:   wr_data = imm;
            WS_SUM:   wr_data = sum;
            WS_DIFF:  wr_data = diff;
            WS_IND:   wr_data = ind_val;
            WS_SRC:   wr_data = s1_val;
            WS_INPUT: wr_data = in_data;
            default:  wr_data = '0;
        endcase
    end

    // Branch when the tested value is nonzero with its sign bit clear.
    always_comb begin
        br_take   = is_jpos && (s1_val != '0) && !s1_val[DATA_W-1];
        br_target = imm[PC_W-1:0];
    end
endmodule

// File: rtl/tam_seq.sv
`timescale 1ns/1ps
// Sequencer: program counter, halt flag and stream handshake control.
// Assumes the instruction at pc stays constant while the core stalls.
// An instruction retires ("advance") only when its handshake completes.
module tam_seq #(
    parameter int PC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_halt,
    input  logic            is_read,
    input  logic            is_print,
    input  logic            br_take,
    input  logic [PC_W-1:0] br_target,
    input  logic            in_valid,
    input  logic            out_ready,
    output logic [PC_W-1:0] pc,
    output logic            halted,
    output logic            advance,
    output logic            in_ready,
    output logic            out_valid
);
    logic wait_in;
    logic wait_out;

    // Stall and handshake decisions for the current instruction.
    always_comb begin
        wait_in   = is_read && !in_valid;
        wait_out  = is_print && !out_ready;
        advance   = !halted && !is_halt && !wait_in && !wait_out;
        in_ready  = !halted && is_read;
        out_valid = !halted && is_print;
    end

    // Program counter and sticky halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halted <= 1'b0;
        end else if (!halted && is_halt) begin
            halted <= 1'b1;
        end else if (advance) begin
            pc <= br_take ? br_target : pc + PC_W'(1);
        end
    end
endmodule

// File: rtl/tam_core.sv
`timescale 1ns/1ps
// Three-address register machine core. Fetches from a combinational
// program ROM, executes one instruction per cycle, and stalls only on the
// input and output streams. Assumes NREG is a power of two and PC_W <= DATA_W.
module tam_core
    import tam_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    parameter int PC_W   = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    output logic [PC_W-1:0]                         rom_addr,
    input  logic [OPC_W+3*$clog2(NREG)+DATA_W-1:0]  rom_data,
    input  logic                                    in_valid,
    output logic                                    in_ready,
    input  logic [DATA_W-1:0]                       in_data,
    output logic                                    out_valid,
    input  logic                                    out_ready,
    output logic [DATA_W-1:0]                       out_data,
    output logic                                    halted
);
    localparam int RA_W = $clog2(NREG);
    localparam int NRD  = 3;
    localparam int P_S1 = 0;
    localparam int P_S2 = 1;
    localparam int P_D  = 2;

    logic [RA_W-1:0]               d_idx, s1_idx, s2_idx;
    logic [DATA_W-1:0]             imm;
    wsel_e                         wsel;
    logic                          is_halt, is_read, is_print, is_jpos;
    logic [NRD-1:0][RA_W-1:0]      rd_idx;
    logic [NRD-1:0][DATA_W-1:0]    rd_data;
    logic [RA_W-1:0]               ind_idx;
    logic [DATA_W-1:0]             ind_val;
    logic                          wr_req, advance, br_take;
    logic [RA_W-1:0]               wr_idx;
    logic [DATA_W-1:0]             wr_data;
    logic [PC_W-1:0]               br_target;

    tam_decode #(.DATA_W(DATA_W), .RA_W(RA_W)) u_dec (
        .instr    (rom_data),
        .d_idx    (d_idx),
        .s1_idx   (s1_idx),
        .s2_idx   (s2_idx),
        .imm      (imm),
        .wsel     (wsel),
        .is_halt  (is_halt),
        .is_read  (is_read),
        .is_print (is_print),
        .is_jpos  (is_jpos)
    );

    // Read-port index routing.
    always_comb begin
        rd_idx[P_S1] = s1_idx;
        rd_idx[P_S2] = s2_idx;
        rd_idx[P_D]  = d_idx;
    end

    tam_regfile #(.DATA_W(DATA_W), .NREG(NREG), .RA_W(RA_W), .NRD(NRD)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req && advance),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .ptr_idx  (ind_idx),
        .ptr_data (ind_val)
    );

    tam_exec #(.DATA_W(DATA_W), .RA_W(RA_W), .PC_W(PC_W)) u_exe (
        .wsel      (wsel),
        .is_jpos   (is_jpos),
        .d_idx     (d_idx),
        .imm       (imm),
        .s1_val    (rd_data[P_S1]),
        .s2_val    (rd_data[P_S2]),
        .d_val     (rd_data[P_D]),
        .ind_val   (ind_val),
        .in_data   (in_data),
        .ind_idx   (ind_idx),
        .wr_req    (wr_req),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .br_take   (br_take),
        .br_target (br_target)
    );

    tam_seq #(.PC_W(PC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_halt   (is_halt),
        .is_read   (is_read),
        .is_print  (is_print),
        .br_take   (br_take && advance),
        .br_target (br_target),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .pc        (rom_addr),
        .halted    (halted),
        .advance   (advance),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    // The printed word is always the first source operand.
    assign out_data = rd_data[P_S1];
endmodule

// File: rtl/tam_core_chk.sv
`timescale 1ns/1ps
// Port-level properties of the three-address core. Assumes the program ROM
// holds a fixed word per address while the core runs.
module tam_core_chk #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   rom_addr,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              halted
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (rom_addr == '0) && !halted);

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(rom_addr));

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !in_ready && !out_valid);

    // R9
    print_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(rom_addr));

    // R8
    read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && !in_valid |=> in_ready && $stable(rom_addr));

    // R12
    one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
endmodule

bind tam_core tam_core_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_addr  (rom_addr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .halted    (halted)
);

// File: tb/tam_core_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped on each rising edge and
// compared with the core on every falling edge, plus directed print checks.
module tam_core_tb_top;
    localparam int DATA_W = 16;
    localparam int NREG   = 16;
    localparam int PC_W   = 8;
    localparam int DEPTH  = 1 << PC_W;
    localparam int INSTR_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [PC_W-1:0]    rom_addr;
    logic [INSTR_W-1:0] rom_data;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [DATA_W-1:0]  in_data = '0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [DATA_W-1:0]  out_data;
    logic               halted;

    logic [INSTR_W-1:0] prog [DEPTH];
    assign rom_data = prog[rom_addr];

    tam_core #(.DATA_W(DATA_W), .NREG(NREG), .PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .halted(halted)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;
    int vin_pct = 50;
    int rdy_pct = 50;

    logic [DATA_W-1:0] in_words [64];
    int in_idx = 0;

    logic [DATA_W-1:0] m_r [NREG];
    int m_pc = 0;
    bit m_halt = 1'b0;
    logic [DATA_W-1:0] m_prints [$];
    logic [DATA_W-1:0] d_prints [$];

    function automatic logic [INSTR_W-1:0] mk(int op, int d, int s1, int s2, int imm);
        return {op[3:0], d[3:0], s1[3:0], s2[3:0], imm[15:0]};
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0: return "R11";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tg, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
        end
    endtask

    // Reference model: one architectural step per rising edge.
    always @(posedge clk) begin : mdl
        logic [INSTR_W-1:0] ins;
        logic [3:0] op, d, s1, s2;
        logic [DATA_W-1:0] imm, a, b, dv;
        int nxt;
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) m_r[i] = '0;
            m_pc = 0;
            m_halt = 1'b0;
        end else if (!m_halt) begin
            ins = prog[m_pc];
            op = ins[31:28]; d = ins[27:24]; s1 = ins[23:20]; s2 = ins[19:16];
            imm = ins[15:0];
            a = m_r[s1]; b = m_r[s2]; dv = m_r[d];
            nxt = (m_pc + 1) % DEPTH;
            case (op)
                4'd0: begin m_halt = 1'b1; nxt = m_pc; end
                4'd1: m_r[d] = imm;
                4'd2: m_r[d] = a + b;
                4'd3: m_r[d] = a - b;
                4'd4: m_r[d] = m_r[a[3:0]];
                4'd5: m_r[dv[3:0]] = a;
                4'd6: if (a != 0 && !a[DATA_W-1]) nxt = imm % DEPTH;
                4'd7: if (in_valid) begin m_r[d] = in_words[in_idx % 64]; in_idx++; end
                      else nxt = m_pc;
                4'd8: if (out_ready) m_prints.push_back(a); else nxt = m_pc;
                default: ;
            endcase
            m_pc = nxt;
        end
    end

    // Falling edge: compare with the model, then drive new handshake inputs.
    always @(negedge clk) begin : cmp
        logic [INSTR_W-1:0] ins;
        logic [3:0] op;
        bit e_in, e_out;
        if (cmp_on && rst_n) begin
            ins = prog[m_pc];
            op = ins[31:28];
            chk(rom_addr == PC_W'(m_pc), tag_of(op), "fetch address", rom_addr, m_pc);
            chk(halted == m_halt, "R11", "halt flag", halted, m_halt);
            e_in  = !m_halt && op == 4'd7;
            e_out = !m_halt && op == 4'd8;
            chk(in_ready == e_in, "R8", "in_ready", in_ready, e_in);
            chk(out_valid == e_out, "R9", "out_valid", out_valid, e_out);
            if (e_out)
                chk(out_data == m_r[ins[23:20]], "R9", "out_data", out_data, m_r[ins[23:20]]);
        end
        in_valid  = ($urandom_range(0, 99) < vin_pct);
        out_ready = ($urandom_range(0, 99) < rdy_pct);
        in_data   = in_words[in_idx % 64];
        if (rst_n && out_valid && out_ready) d_prints.push_back(out_data);
    end

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 1'b0;
        m_prints.delete();
        d_prints.delete();
        in_idx = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset release
        chk(rom_addr == '0, "R1", "fetch address after reset", rom_addr, 0);
        chk(halted == 1'b0, "R1", "halt flag after reset", halted, 0);
    endtask

    task automatic run_until_halt(input int limit);
        int n = 0;
        while (!halted && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic fill_halt();
        for (int i = 0; i < DEPTH; i++) prog[i] = mk(0, 0, 0, 0, 0);
    endtask

    logic [DATA_W-1:0] exp_d [12];
    string exp_t [12];

    initial begin
        for (int i = 0; i < 64; i++) in_words[i] = DATA_W'($urandom);
        in_words[0] = 16'h1234;
        in_words[1] = 16'hABCD;
        fill_halt();
        cmp_on = 1'b1;

        // Directed program
        prog[0]  = mk(1, 15, 0, 0, 16'h7FFF);
        prog[1]  = mk(8, 0, 15, 0, 0);
        prog[2]  = mk(1, 1, 0, 0, 5);
        prog[3]  = mk(1, 2, 0, 0, 3);
        prog[4]  = mk(2, 3, 1, 2, 0);
        prog[5]  = mk(8, 0, 3, 0, 0);
        prog[6]  = mk(2, 1, 1, 1, 0);
        prog[7]  = mk(8, 0, 1, 0, 0);
        prog[8]  = mk(3, 4, 2, 1, 0);
        prog[9]  = mk(8, 0, 4, 0, 0);
        prog[10] = mk(3, 2, 2, 2, 0);
        prog[11] = mk(8, 0, 2, 0, 0);
        prog[12] = mk(1, 5, 0, 0, 16'h0013);
        prog[13] = mk(4, 6, 5, 0, 0);
        prog[14] = mk(8, 0, 6, 0, 0);
        prog[15] = mk(1, 7, 0, 0, 9);
        prog[16] = mk(5, 5, 7, 0, 0);
        prog[17] = mk(8, 0, 3, 0, 0);
        prog[18] = mk(7, 8, 0, 0, 0);
        prog[19] = mk(8, 0, 8, 0, 0);
        prog[20] = mk(1, 9, 0, 0, 2);
        prog[21] = mk(1, 10, 0, 0, 1);
        prog[22] = mk(3, 9, 9, 10, 0);
        prog[23] = mk(8, 0, 9, 0, 0);
        prog[24] = mk(6, 0, 9, 0, 22);
        prog[25] = mk(6, 0, 4, 0, 0);
        prog[26] = mk(6, 0, 0, 0, 0);
        prog[27] = mk(1, 11, 0, 0, 16'h8000);
        prog[28] = mk(6, 0, 11, 0, 0);
        prog[29] = mk(1, 12, 0, 0, 12);
        prog[30] = mk(4, 12, 12, 0, 0);
        prog[31] = mk(8, 0, 12, 0, 0);
        prog[32] = mk(15, 3, 1, 2, 16'hFFFF);
        prog[33] = mk(7, 13, 0, 0, 0);
        prog[34] = mk(8, 0, 13, 0, 0);
        prog[35] = mk(0, 0, 0, 0, 0);

        exp_d[0] = 16'h7FFF; exp_t[0] = "R2";
        exp_d[1] = 16'h0008; exp_t[1] = "R3";
        exp_d[2] = 16'h000A; exp_t[2] = "R10";
        exp_d[3] = 16'hFFF9; exp_t[3] = "R4";
        exp_d[4] = 16'h0000; exp_t[4] = "R4";
        exp_d[5] = 16'h0008; exp_t[5] = "R5";
        exp_d[6] = 16'h0009; exp_t[6] = "R6";
        exp_d[7] = 16'h1234; exp_t[7] = "R8";
        exp_d[8] = 16'h0001; exp_t[8] = "R7";
        exp_d[9] = 16'h0000; exp_t[9] = "R7";
        exp_d[10] = 16'h000C; exp_t[10] = "R5";
        exp_d[11] = 16'hABCD; exp_t[11] = "R12";

        vin_pct = 50; rdy_pct = 50;
        do_reset();
        run_until_halt(3000);
        chk(d_prints.size() == 12, "R9", "directed print count", d_prints.size(), 12);
        for (int i = 0; i < 12 && i < d_prints.size(); i++)
            chk(d_prints[i] == exp_d[i], exp_t[i], "directed print value", d_prints[i], exp_d[i]);

        // R11: halted core stays frozen and quiet
        begin
            logic [PC_W-1:0] held;
            held = rom_addr;
            vin_pct = 100; rdy_pct = 100;
            repeat (20) @(negedge clk);
            chk(halted == 1'b1, "R11", "halt flag held", halted, 1);
            chk(rom_addr == held, "R11", "fetch address frozen", rom_addr, held);
            chk(!in_ready && !out_valid, "R11", "no handshake while halted",
                {in_ready, out_valid}, 0);
        end

        // R1: registers cleared by reset (r3 was written above)
        fill_halt();
        prog[0] = mk(8, 0, 3, 0, 0);
        prog[1] = mk(8, 0, 14, 0, 0);
        do_reset();
        run_until_halt(200);
        chk(d_prints.size() == 2, "R1", "print count after reset", d_prints.size(), 2);
        for (int i = 0; i < d_prints.size(); i++)
            chk(d_prints[i] == '0, "R1", "register cleared by reset", d_prints[i], 0);

        // Random programs against the model, varied handshake rates
        for (int run = 0; run < 6; run++) begin
            fill_halt();
            for (int i = 0; i < 64; i++) begin
                int op;
                op = ($urandom_range(0, 99) < 2) ? 0 : $urandom_range(1, 15);
                prog[i] = mk(op, $urandom_range(0, 15), $urandom_range(0, 15),
                             $urandom_range(0, 15),
                             (op == 6) ? $urandom_range(0, 63) : $urandom_range(0, 65535));
            end
            case (run % 3)
                0: begin vin_pct = 100; rdy_pct = 100; end
                1: begin vin_pct = 30;  rdy_pct = 70;  end
                default: begin vin_pct = 80; rdy_pct = 20; end
            endcase
            do_reset();
            run_until_halt(800);
            chk(d_prints.size() == m_prints.size(), "R9", "random print count",
                d_prints.size(), m_prints.size());
            for (int i = 0; i < d_prints.size() && i < m_prints.size(); i++)
                chk(d_prints[i] == m_prints[i], "R10", "random print value",
                    d_prints[i], m_prints[i]);
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule